// File: doc/BRIEF.md
# PWM Time-Base Counter with Compare Events

This block is the timing core of a pulse-width modulator. A 16-bit counter advances once per tick of a programmable clock divider and runs against a period value in one of three patterns: counting up and wrapping to zero, counting down and reloading the period, or rising to the period and falling back to zero. Four compare values are checked against the counter on every tick. Each match is reported as a one-clock pulse on an up-tagged or a down-tagged line. Separate pulses mark the counter landing on zero and landing on the period. A direction output shows which way the next step goes.

Configuration is written through a write-enable, address and data port. The period and the first two compare values are double-buffered. A write lands in a holding copy, and that copy is moved to the working copy only when the counter lands on zero, on the period, or on either, as selected per register. This keeps a change from taking effect partway through a PWM cycle. The same selection also offers a direct mode in which a write reaches the working copy at once. The third and fourth compare values are always written directly. Downstream waveform and trigger logic consumes the pulses.

Top module: `pwm_timebase`

## Requirements
- R1: After synchronous reset the counter is 0, the direction output is 1, every event output is 0, the mode is halted, and every stored register value is 0.
- R2: With mode code 0 (up), each tick moves the counter to count+1. When the count is at or above the working period, the tick moves it to 0 instead. One cycle is period+1 ticks.
- R3: With mode code 1 (down), each tick moves the counter to count-1. When the count is 0, the tick loads the working period instead. One cycle is period+1 ticks.
- R4: With mode code 2 (up-down), the counter steps by one towards the period, then by one back towards 0, then repeats. One cycle is 2*period ticks. With a period of 0 the counter stays at 0.
- R5: An event is registered in the clock edge of the tick that produces the new count, and is visible together with that count. The zero pulse means the new count is 0. The period pulse means it equals the working period. Compare pulse i sits on bit i of the up or down vector, depending on the direction of that step. A wrap to 0 counts as an up step, and a reload to the period counts as a down step. Per cycle, a compare value within range fires once in up and down modes. In up-down mode it fires twice, once on each slope, except at 0 (down only) and at the period (up only).
- R6: Address 2 holds the period, and addresses 3 and 4 hold compare A and B. Each of these is written into a holding copy. The copy moves to the working value on a tick whose new count meets the load code of that register: 0 means zero, 1 means the working period, 2 means either. The load codes sit at address 7, in bits [1:0] for the period, [3:2] for A and [5:4] for B.
- R7: Load code 3 makes a write to that register take effect in the working copy on the write edge itself.
- R8: Mode code 3 halts the counter. It holds its count and direction, no event is produced, and the divider is held cleared. Selecting a counting mode again resumes from the held count.
- R9: The divider value at address 1 (bits [7:0]) gives one tick every divider+1 clocks while counting.
- R10: The direction output is 1 in up mode and 0 in down mode. In up-down mode it drops to 0 once the count reaches the period and returns to 1 once it reaches 0.
- R11: Address 0 bits [1:0] select the mode. Addresses 5 and 6 write compare C and D directly to their working values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| dir_up_o | output | 1 | Direction of the next step, 1 = up |
| zero_o | output | 1 | Counter landed on zero |
| prd_o | output | 1 | Counter landed on the period |
| cmp_up_o | output | 4 | Compare matches reached on an up step, bit i = compare i |
| cmp_dn_o | output | 4 | Compare matches reached on a down step, bit i = compare i |

## Verification
The bench builds the block with its default widths, a 16-bit counter and an 8-bit divider. At run time it programs periods from 0 to 5 and divider values from 0 to 2. This keeps every counting cycle within a few tens of clocks, so all three modes, each compare placement (at 0, at the period, mid-range and out of range) and every load code can be swept in full. Expected event counts per window follow arithmetically from the period and mode. A cycle-level reference also checks the counter and event outputs on every clock, including register writes made mid-cycle.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_UPDOWN = 2'd2,
    CM_HALT   = 2'd3
  } cmode_e;

  typedef enum logic [1:0] {
    LD_ZERO = 2'd0,
    LD_PRD  = 2'd1,
    LD_BOTH = 2'd2,
    LD_IMM  = 2'd3
  } ldmode_e;

  localparam int REG_AW   = 3;
  localparam int ADR_MODE = 0;
  localparam int ADR_DIV  = 1;
  localparam int ADR_PRD  = 2;
  localparam int ADR_CMP0 = 3;
  localparam int ADR_LDM  = 7;

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] pc_q;

  assign tick_o = run_i && (pc_q >= div_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (!run_i || tick_o) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  // A tick with a non-zero divider is never followed directly by another.
  assert_tick_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

  // Halted: no tick.
  assert_no_tick_halt_R8: assert property (@(posedge clk) disable iff (rst)
    !run_i |-> !tick_o);

endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg
  import pwm_tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  ldmode_e      lmode_i,
  input  logic         tick_i,
  input  logic         at_zero_i,
  input  logic         at_prd_i,
  output logic [W-1:0] act_o
);

  logic [W-1:0] hold_q;
  logic [W-1:0] act_q;
  logic         load;

  always_comb begin
    load = 1'b0;
    unique case (lmode_i)
      LD_ZERO: load = at_zero_i;
      LD_PRD:  load = at_prd_i;
      LD_BOTH: load = at_zero_i || at_prd_i;
      default: load = 1'b0;
    endcase
    load = load && tick_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i) hold_q <= wdata_i;
      if (wr_i && lmode_i == LD_IMM) begin
        act_q <= wdata_i;
      end else if (load) begin
        act_q <= hold_q;
      end
    end
  end

  assign act_o = act_q;

  // Working value only moves on a tick or on a direct-mode write.
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !(wr_i && lmode_i == LD_IMM)) |=> $stable(act_o));

  // A direct-mode write is visible on the next cycle.
  assert_direct_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_i && lmode_i == LD_IMM) |=> (act_o == $past(wdata_i)));

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
  import pwm_tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  cmode_e       mode_i,
  input  logic         tick_i,
  input  logic [W-1:0] prd_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_o,
  output logic [W-1:0] nxt_o,
  output logic         step_up_o
);

  logic [W-1:0] cnt_q;
  logic         dir_q;
  logic         dir_nx;
  logic         go_up;

  always_comb begin
    nxt_o     = cnt_q;
    step_up_o = dir_q;
    dir_nx    = dir_q;
    go_up     = 1'b0;
    unique case (mode_i)
      CM_UP: begin
        nxt_o     = (cnt_q >= prd_i) ? '0 : cnt_q + 1'b1;
        step_up_o = 1'b1;
        dir_nx    = 1'b1;
      end
      CM_DOWN: begin
        nxt_o     = (cnt_q == '0) ? prd_i : cnt_q - 1'b1;
        step_up_o = 1'b0;
        dir_nx    = 1'b0;
      end
      CM_UPDOWN: begin
        if (prd_i == '0) begin
          nxt_o     = '0;
          step_up_o = 1'b1;
          dir_nx    = 1'b1;
        end else begin
          go_up = (dir_q && cnt_q < prd_i) || (!dir_q && cnt_q == '0);
          if (go_up) begin
            nxt_o     = cnt_q + 1'b1;
            step_up_o = 1'b1;
            dir_nx    = (nxt_o < prd_i);
          end else begin
            nxt_o     = cnt_q - 1'b1;
            step_up_o = 1'b0;
            dir_nx    = (nxt_o == '0);
          end
        end
      end
      default: begin
        nxt_o     = cnt_q;
        step_up_o = dir_q;
        dir_nx    = dir_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      if (tick_i) cnt_q <= nxt_o;
      unique case (mode_i)
        CM_UP:     dir_q <= 1'b1;
        CM_DOWN:   dir_q <= 1'b0;
        CM_UPDOWN: if (tick_i) dir_q <= dir_nx;
        default:   dir_q <= dir_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && mode_i == CM_UP && cnt_o >= prd_i) |=> (cnt_o == '0));

  assert_down_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && mode_i == CM_DOWN && cnt_o == '0) |=> (cnt_o == $past(prd_i)));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && mode_i == CM_UPDOWN && prd_i != '0 && cnt_o <= prd_i)
    |=> (cnt_o == $past(cnt_o) + W'(1) || cnt_o == $past(cnt_o) - W'(1)));

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == CM_HALT) |=> ($stable(cnt_o) && $stable(dir_o)));

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic [W-1:0]        nxt_i,
  input  logic                step_up_i,
  input  logic [W-1:0]        prd_i,
  input  logic [N-1:0][W-1:0] cmp_i,
  output logic                zero_o,
  output logic                prd_o,
  output logic [N-1:0]        cmp_up_o,
  output logic [N-1:0]        cmp_dn_o
);

  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = (nxt_i == cmp_i[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_o   <= 1'b0;
      prd_o    <= 1'b0;
      cmp_up_o <= '0;
      cmp_dn_o <= '0;
    end else begin
      zero_o   <= tick_i && (nxt_i == '0);
      prd_o    <= tick_i && (nxt_i == prd_i);
      cmp_up_o <= (tick_i && step_up_i)  ? hit : '0;
      cmp_dn_o <= (tick_i && !step_up_i) ? hit : '0;
    end
  end

  assert_tag_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_up_o & cmp_dn_o) == '0);

  assert_no_event_without_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> (!zero_o && !prd_o && cmp_up_o == '0 && cmp_dn_o == '0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tbase_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o,
  output logic             zero_o,
  output logic             prd_o,
  output logic [3:0]       cmp_up_o,
  output logic [3:0]       cmp_dn_o
);

  localparam int N_CMP    = 4;
  localparam int N_SHADOW = 2;
  localparam int LDM_W    = 2 * (N_SHADOW + 1);

  cmode_e                       mode_q;
  logic [PRE_W-1:0]             div_q;
  logic [LDM_W-1:0]             ldm_q;
  logic                         tick;
  logic                         run;
  logic [CNT_W-1:0]             prd_act;
  logic [CNT_W-1:0]             nxt;
  logic                         step_up;
  logic                         at_zero;
  logic                         at_prd;
  logic [N_CMP-1:0][CNT_W-1:0]  cmp_act;
  logic                         sel_prd;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= CM_HALT;
      div_q  <= '0;
      ldm_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_AW'(ADR_MODE)) mode_q <= cmode_e'(wr_data[1:0]);
      if (wr_addr == REG_AW'(ADR_DIV))  div_q  <= wr_data[PRE_W-1:0];
      if (wr_addr == REG_AW'(ADR_LDM))  ldm_q  <= wr_data[LDM_W-1:0];
    end
  end

  assign run     = (mode_q != CM_HALT);
  assign at_zero = (nxt == '0);
  assign at_prd  = (nxt == prd_act);
  assign sel_prd = wr_en && (wr_addr == REG_AW'(ADR_PRD));

  pwm_prescale #(.DIV_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  pwm_shadow_reg #(.W(CNT_W)) u_prd (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (sel_prd),
    .wdata_i   (wr_data),
    .lmode_i   (ldmode_e'(ldm_q[1:0])),
    .tick_i    (tick),
    .at_zero_i (at_zero),
    .at_prd_i  (at_prd),
    .act_o     (prd_act)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    localparam logic [REG_AW-1:0] ADR = REG_AW'(ADR_CMP0 + g);
    logic sel;
    assign sel = wr_en && (wr_addr == ADR);
    if (g < N_SHADOW) begin : g_sh
      pwm_shadow_reg #(.W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (sel),
        .wdata_i   (wr_data),
        .lmode_i   (ldmode_e'(ldm_q[2*g+2 +: 2])),
        .tick_i    (tick),
        .at_zero_i (at_zero),
        .at_prd_i  (at_prd),
        .act_o     (cmp_act[g])
      );
    end else begin : g_direct
      logic [CNT_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (rst)      val_q <= '0;
        else if (sel) val_q <= wr_data;
      end
      assign cmp_act[g] = val_q;
    end
  end

  pwm_count_core #(.W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_q),
    .tick_i    (tick),
    .prd_i     (prd_act),
    .cnt_o     (count_o),
    .dir_o     (dir_up_o),
    .nxt_o     (nxt),
    .step_up_o (step_up)
  );

  pwm_match_bank #(.W(CNT_W), .N(N_CMP)) u_match (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .nxt_i     (nxt),
    .step_up_i (step_up),
    .prd_i     (prd_act),
    .cmp_i     (cmp_act),
    .zero_o    (zero_o),
    .prd_o     (prd_o),
    .cmp_up_o  (cmp_up_o),
    .cmp_dn_o  (cmp_dn_o)
  );

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    zero_o |-> (count_o == '0));

  assert_dir_up_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_q == CM_UP) |=> dir_up_o);

  assert_dir_down_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_q == CM_DOWN) |=> !dir_up_o);

endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o;
  logic        dir_up_o, zero_o, prd_o;
  logic [3:0]  cmp_up_o, cmp_dn_o;

  pwm_timebase u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .dir_up_o(dir_up_o), .zero_o(zero_o), .prd_o(prd_o),
    .cmp_up_o(cmp_up_o), .cmp_dn_o(cmp_dn_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // reference state, derived from the requirements
  logic [15:0] m_cnt, m_psh, m_pact;
  logic        m_dir, m_z, m_p;
  logic [1:0]  m_mode;
  logic [7:0]  m_div, m_pc;
  logic [5:0]  m_lm;
  logic [15:0] m_csh [4];
  logic [15:0] m_cact [4];
  logic [3:0]  m_cu, m_cd;

  function automatic bit ld_hit(input logic [1:0] code, input bit lz, input bit lp);
    case (code)
      2'd0: return lz;
      2'd1: return lp;
      2'd2: return lz || lp;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    bit tk, su, dn, gu, lz, lp;
    logic [15:0] nx;
    if (rst) begin
      m_cnt = '0; m_dir = 1'b1; m_mode = 2'd3; m_div = '0; m_pc = '0;
      m_psh = '0; m_pact = '0; m_lm = '0; m_z = 0; m_p = 0; m_cu = '0; m_cd = '0;
      for (int i = 0; i < 4; i++) begin m_csh[i] = '0; m_cact[i] = '0; end
    end else begin
      tk = (m_mode != 2'd3) && (m_pc >= m_div);
      nx = m_cnt; su = m_dir; dn = m_dir;
      case (m_mode)
        2'd0: begin nx = (m_cnt >= m_pact) ? 16'd0 : m_cnt + 16'd1; su = 1; dn = 1; end
        2'd1: begin nx = (m_cnt == 16'd0) ? m_pact : m_cnt - 16'd1; su = 0; dn = 0; end
        2'd2: begin
          if (m_pact == 16'd0) begin nx = 16'd0; su = 1; dn = 1; end
          else begin
            gu = (m_dir && m_cnt < m_pact) || (!m_dir && m_cnt == 16'd0);
            if (gu) begin nx = m_cnt + 16'd1; su = 1; dn = (nx < m_pact); end
            else    begin nx = m_cnt - 16'd1; su = 0; dn = (nx == 16'd0); end
          end
        end
        default: ;
      endcase
      m_z = tk && (nx == 16'd0);
      m_p = tk && (nx == m_pact);
      for (int i = 0; i < 4; i++) begin
        m_cu[i] = tk && su && (nx == m_cact[i]);
        m_cd[i] = tk && !su && (nx == m_cact[i]);
      end
      lz = tk && (nx == 16'd0);
      lp = tk && (nx == m_pact);
      if (m_lm[1:0] == 2'd3 && wr_en && wr_addr == 3'd2) m_pact = wr_data;
      else if (ld_hit(m_lm[1:0], lz, lp)) m_pact = m_psh;
      for (int i = 0; i < 2; i++) begin
        if (m_lm[2*i+2 +: 2] == 2'd3 && wr_en && wr_addr == 3'(3 + i)) m_cact[i] = wr_data;
        else if (ld_hit(m_lm[2*i+2 +: 2], lz, lp)) m_cact[i] = m_csh[i];
        if (wr_en && wr_addr == 3'(3 + i)) m_csh[i] = wr_data;
      end
      for (int i = 2; i < 4; i++)
        if (wr_en && wr_addr == 3'(3 + i)) m_cact[i] = wr_data;
      if (wr_en && wr_addr == 3'd2) m_psh = wr_data;
      m_pc = (m_mode == 2'd3 || tk) ? 8'd0 : m_pc + 8'd1;
      if (tk) m_cnt = nx;
      case (m_mode)
        2'd0: m_dir = 1'b1;
        2'd1: m_dir = 1'b0;
        2'd2: if (tk) m_dir = dn;
        default: ;
      endcase
      if (wr_en && wr_addr == 3'd0) m_mode = wr_data[1:0];
      if (wr_en && wr_addr == 3'd1) m_div = wr_data[7:0];
      if (wr_en && wr_addr == 3'd7) m_lm = wr_data[5:0];
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  int          c_z, c_p, c_chg;
  int          c_cu [4];
  int          c_cd [4];
  logic [15:0] prev_cnt = '0;

  task automatic clr_counts();
    c_z = 0; c_p = 0; c_chg = 0;
    for (int i = 0; i < 4; i++) begin c_cu[i] = 0; c_cd[i] = 0; end
  endtask

  task automatic step();
    logic [31:0] got, exp;
    @(negedge clk);
    got = {5'd0, count_o, dir_up_o, zero_o, prd_o, cmp_up_o, cmp_dn_o};
    exp = {5'd0, m_cnt, m_dir, m_z, m_p, m_cu, m_cd};
    chk(got === exp, "cycle outputs", int'(got), int'(exp));
    if (zero_o) c_z++;
    if (prd_o) c_p++;
    for (int i = 0; i < 4; i++) begin
      if (cmp_up_o[i]) c_cu[i]++;
      if (cmp_dn_o[i]) c_cd[i]++;
    end
    if (count_o != prev_cnt) c_chg++;
    prev_cnt = count_o;
  endtask

  task automatic wreg(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    step();
    wr_en = 1'b0;
  endtask

  function automatic int exp_hits(input int md, input int pr, input int c, input bit up);
    if (md == 0) return (up && c <= pr) ? 3 : 0;
    if (md == 1) return (!up && c <= pr) ? 3 : 0;
    if (pr == 0) return (up && c == 0) ? 3 : 0;
    if (c > pr) return 0;
    if (c == 0) return up ? 0 : 3;
    if (c == pr) return up ? 3 : 0;
    return 3;
  endfunction

  task automatic setup(input int md, input int pr, input int dv, input int ldm);
    wreg(0, 3);
    wreg(7, 16'h3F);
    wreg(1, dv);
    wreg(2, pr);
    wreg(7, ldm);
    wreg(0, md);
  endtask

  initial begin : wdog
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int h, mx;
    int cv [4];
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    tag = "R1";
    step();
    chk(count_o == 16'd0, "count after reset", int'(count_o), 0);
    chk(dir_up_o == 1'b1, "dir after reset", int'(dir_up_o), 1);
    chk({zero_o, prd_o, cmp_up_o, cmp_dn_o} == 10'd0, "events after reset", 0, 0);
    repeat (4) step();
    chk(count_o == 16'd0, "halted after reset", int'(count_o), 0);

    // R2 R3 R4 R5 R9 R11: sweep of mode, period, divider and compare placement
    for (int md = 0; md < 3; md++) begin
      for (int pr = 0; pr < 6; pr++) begin
        if (pr == 4) continue;
        for (int dv = 0; dv < 3; dv++) begin
          int cyc;
          tag = (md == 0) ? "R2" : (md == 1) ? "R3" : "R4";
          cv[0] = 0; cv[1] = pr; cv[2] = pr / 2; cv[3] = pr + 1;
          wreg(0, 3);
          wreg(7, 16'h3F);
          wreg(1, dv);
          wreg(2, pr);
          for (int i = 0; i < 4; i++) wreg(3 + i, cv[i]);
          wreg(0, md);
          cyc = (md < 2) ? pr + 1 : ((pr == 0) ? 1 : 2 * pr);
          repeat ((2 * cyc + 8) * (dv + 1)) step();
          clr_counts();
          repeat (3 * cyc * (dv + 1)) step();
          chk(c_z == 3, "zero pulses in 3 cycles", c_z, 3);
          chk(c_p == 3, "period pulses in 3 cycles", c_p, 3);
          tag = "R5";
          for (int i = 0; i < 4; i++) begin
            chk(c_cu[i] == exp_hits(md, pr, cv[i], 1'b1), "up-tagged compare count", c_cu[i], exp_hits(md, pr, cv[i], 1'b1));
            chk(c_cd[i] == exp_hits(md, pr, cv[i], 1'b0), "down-tagged compare count", c_cd[i], exp_hits(md, pr, cv[i], 1'b0));
          end
        end
      end
    end

    // R6: period load at zero keeps the old period until the wrap
    tag = "R6";
    setup(0, 5, 0, 16'h3C);
    while (count_o != 16'd1) step();
    wreg(2, 2);
    mx = 0;
    while (!zero_o) begin
      if (int'(count_o) > mx) mx = int'(count_o);
      step();
    end
    chk(mx == 5, "old period held until zero", mx, 5);
    clr_counts();
    repeat (9) step();
    chk(c_z == 3, "new period after zero load", c_z, 3);

    // R6: load at period and at either point, mid-cycle writes, all modes
    for (int lm = 0; lm < 3; lm++) begin
      for (int md = 0; md < 3; md++) begin
        setup(md, 4, 0, 16'h3F);
        wreg(3, 2);
        wreg(7, lm | (lm << 2) | 48);
        repeat (7) step();
        wreg(2, 2);
        wreg(3, 1);
        repeat (12) step();
        wreg(2, 5);
        repeat (15) step();
      end
    end

    // R7: direct write of the period takes effect at once
    tag = "R7";
    setup(0, 5, 0, 16'h3F);
    repeat (4) step();
    wreg(2, 2);
    step();
    for (int i = 0; i < 20; i++) begin
      chk(count_o <= 16'd2, "count bounded by new period", int'(count_o), 2);
      step();
    end

    // R8: halt holds count and events, resume continues
    tag = "R8";
    setup(0, 5, 0, 16'h3F);
    repeat (3) step();
    wreg(0, 3);
    h = int'(count_o);
    for (int i = 0; i < 20; i++) begin
      step();
      chk(int'(count_o) == h, "count held while halted", int'(count_o), h);
      chk({zero_o, prd_o, cmp_up_o, cmp_dn_o} == 10'd0, "no events while halted", 1, 0);
    end
    wreg(0, 0);
    step();
    chk(int'(count_o) == ((h >= 5) ? 0 : h + 1), "resume from held count", int'(count_o), (h >= 5) ? 0 : h + 1);

    // R9: tick rate set by the divider
    tag = "R9";
    setup(0, 5, 3, 16'h3F);
    repeat (12) step();
    clr_counts();
    repeat (40) step();
    chk(c_chg == 10, "count steps in 40 clocks, divider 3", c_chg, 10);
    setup(0, 5, 0, 16'h3F);
    repeat (4) step();
    clr_counts();
    repeat (12) step();
    chk(c_chg == 12, "count steps in 12 clocks, divider 0", c_chg, 12);

    // R10: direction output
    tag = "R10";
    setup(2, 4, 0, 16'h3F);
    repeat (10) step();
    for (int i = 0; i < 24; i++) begin
      step();
      if (count_o == 16'd4) chk(dir_up_o == 1'b0, "dir low at period", int'(dir_up_o), 0);
      if (count_o == 16'd0) chk(dir_up_o == 1'b1, "dir high at zero", int'(dir_up_o), 1);
    end
    setup(1, 4, 0, 16'h3F);
    repeat (3) step();
    chk(dir_up_o == 1'b0, "dir low in down mode", int'(dir_up_o), 0);
    setup(0, 4, 0, 16'h3F);
    repeat (3) step();
    chk(dir_up_o == 1'b1, "dir high in up mode", int'(dir_up_o), 1);

    // R11: compare C and D written directly, seen on the next match
    tag = "R11";
    setup(0, 5, 0, 16'h3F);
    wreg(5, 4);
    wreg(6, 2);
    clr_counts();
    repeat (12) step();
    chk(c_cu[2] == 2, "compare C matches", c_cu[2], 2);
    chk(c_cu[3] == 2, "compare D matches", c_cu[3], 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule